// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block executes the length-setting operation of a vector unit. Each request carries an application vector length, two flags telling whether the destination and source operands are the zero register, an element-width code and a register-grouping code. The block works out how many elements fit in the selected register group (VLMAX). It then records the new vector length and the new type fields, and it returns the granted length for the destination register.

The grouping factor can be a whole multiple (1, 2, 4, 8) or a fraction (1/2, 1/4, 1/8). A fraction shortens VLMAX. When a combination leaves less than one element, or when a code is reserved, the configuration is marked illegal and the length becomes zero. A zero source operand changes how the request is read. With a live destination it asks for the largest legal length. With a zero destination as well, it keeps the current length and replaces only the type. A constant output gives the register width in bytes.

Top module: `vlcfg_unit`

## Requirements
- R1: After reset, vl_o is 0, ill_o is 1, sew_o and lmul_o are 0 and rd_wen_o is 0.
- R2: vl_o, sew_o, lmul_o and ill_o change only at a clock edge where cfg_valid_i is 1, and they show the new values from that edge onward.
- R3: For a legal request with a nonzero source operand, vl_o becomes avl_i when avl_i < VLMAX and becomes VLMAX otherwise. VLMAX = VLEN*LMUL/SEW. The SEW code maps 0,1,2,3 to 8,16,32,64 bits. The LMUL code maps 0,1,2,3 to 1,2,4,8.
- R4: When rs1_zero_i is 1 and rd_zero_i is 0, vl_o becomes VLMAX, whatever the value of avl_i.
- R5: When rs1_zero_i and rd_zero_i are both 1 and the request is legal, vl_o keeps its previous value. sew_o and lmul_o take the requested codes.
- R6: LMUL codes 7, 6 and 5 select 1/2, 1/4 and 1/8. VLMAX is then divided by 2, 4 or 8 compared with LMUL=1.
- R7: A request is illegal if its SEW code is 4 to 7, if its LMUL code is 4, or if it gives VLMAX < 1. An illegal request sets ill_o to 1 and forces vl_o, sew_o and lmul_o to 0, whatever the operand flags are.
- R8: rd_wen_o is 1 for exactly the one cycle after an accepted request with rd_zero_i = 0, and in that cycle rd_wdata_o equals the new vl_o. A request with rd_zero_i = 1 leaves rd_wen_o at 0.
- R9: vlenb_o always equals VLEN/8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid_i | input | 1 | One-cycle strobe that accepts a request |
| avl_i | input | XLEN | Requested application vector length |
| rd_zero_i | input | 1 | Destination operand is the zero register |
| rs1_zero_i | input | 1 | Source operand is the zero register |
| sew_i | input | 3 | Element width code |
| lmul_i | input | 3 | Register grouping code |
| vl_o | output | $clog2(VLEN)+1 | Current vector length |
| sew_o | output | 3 | Current element width code |
| lmul_o | output | 3 | Current grouping code |
| ill_o | output | 1 | Current configuration is illegal |
| rd_wen_o | output | 1 | Write strobe for the destination register |
| rd_wdata_o | output | XLEN | Value for the destination register |
| vlenb_o | output | XLEN | Register width in bytes |

## Verification
The bench covers requests that land just below, exactly on and far above VLMAX. A design with an off-by-one comparison would grant VLMAX+1 or cut an exact request short. It runs every fractional grouping, including the widest element at 1/8 where VLMAX drops below one. A design that lets the shift wrap would report a large length there and leave ill_o clear. The two zero-operand forms are checked against each other, and the keep form is also checked against an illegal type. A design that mixes up the flags would either overwrite a kept length or ignore a request for the maximum. The bench also drives changing inputs with no strobe, so a design that updates without cfg_valid_i is caught.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;

    typedef enum logic [2:0] {
        SEW_E8  = 3'd0,
        SEW_E16 = 3'd1,
        SEW_E32 = 3'd2,
        SEW_E64 = 3'd3
    } sew_code_e;

    typedef enum logic [2:0] {
        GRP_X1   = 3'd0,
        GRP_X2   = 3'd1,
        GRP_X4   = 3'd2,
        GRP_X8   = 3'd3,
        GRP_RSVD = 3'd4,
        GRP_F8   = 3'd5,
        GRP_F4   = 3'd6,
        GRP_F2   = 3'd7
    } grp_code_e;

    // Grouping exponent as a signed log2 value: -3..3
    function automatic logic signed [7:0] grp_exp(input logic [2:0] code);
        logic signed [7:0] r;
        case (code)
            GRP_X1:  r = 8'sd0;
            GRP_X2:  r = 8'sd1;
            GRP_X4:  r = 8'sd2;
            GRP_X8:  r = 8'sd3;
            GRP_F8:  r = -8'sd3;
            GRP_F4:  r = -8'sd2;
            GRP_F2:  r = -8'sd1;
            default: r = 8'sd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vlcfg_vlmax.sv
module vlcfg_vlmax #(
    parameter int VLEN = 128,
    localparam int VLW = $clog2(VLEN) + 1,
    localparam int LOG2_VLEN = $clog2(VLEN)
) (
    input  logic [2:0]     sew_i,
    input  logic [2:0]     lmul_i,
    output logic [VLW-1:0] vlmax_o,
    output logic           ill_o
);
    import vlcfg_pkg::*;

    logic signed [7:0] exp_s;
    logic              rsvd;

    always_comb begin
        rsvd  = sew_i[2] || (lmul_i == GRP_RSVD);
        exp_s = 8'(LOG2_VLEN) - 8'sd3 - $signed({6'b0, sew_i[1:0]}) + grp_exp(lmul_i);
        if (rsvd || exp_s < 0) begin
            ill_o   = 1'b1;
            vlmax_o = '0;
        end else begin
            ill_o   = 1'b0;
            vlmax_o = VLW'(1) << exp_s[4:0];
        end
    end

endmodule

// File: rtl/vlcfg_select.sv
module vlcfg_select #(
    parameter int VLEN = 128,
    parameter int XLEN = 32,
    localparam int VLW = $clog2(VLEN) + 1
) (
    input  logic [XLEN-1:0] avl_i,
    input  logic [VLW-1:0]  vlmax_i,
    input  logic            ill_i,
    input  logic            rd_zero_i,
    input  logic            rs1_zero_i,
    input  logic [VLW-1:0]  cur_vl_i,
    output logic [VLW-1:0]  nxt_vl_o
);
    always_comb begin
        if (ill_i) begin
            nxt_vl_o = '0;
        end else if (rs1_zero_i && rd_zero_i) begin
            nxt_vl_o = cur_vl_i;
        end else if (rs1_zero_i) begin
            nxt_vl_o = vlmax_i;
        end else if (avl_i < XLEN'(vlmax_i)) begin
            nxt_vl_o = VLW'(avl_i);
        end else begin
            nxt_vl_o = vlmax_i;
        end
    end

endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit #(
    parameter int VLEN = 128,
    parameter int XLEN = 32,
    localparam int VLW = $clog2(VLEN) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_valid_i,
    input  logic [XLEN-1:0] avl_i,
    input  logic            rd_zero_i,
    input  logic            rs1_zero_i,
    input  logic [2:0]      sew_i,
    input  logic [2:0]      lmul_i,
    output logic [VLW-1:0]  vl_o,
    output logic [2:0]      sew_o,
    output logic [2:0]      lmul_o,
    output logic            ill_o,
    output logic            rd_wen_o,
    output logic [XLEN-1:0] rd_wdata_o,
    output logic [XLEN-1:0] vlenb_o
);
    typedef struct packed {
        logic [VLW-1:0]  vl;
        logic [2:0]      sew;
        logic [2:0]      lmul;
        logic            ill;
        logic            rd_wen;
        logic [XLEN-1:0] rd_data;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    logic [VLW-1:0] vlmax_w;
    logic           ill_w;
    logic [VLW-1:0] nxt_vl_w;

    vlcfg_vlmax #(.VLEN(VLEN)) vlmax_i (
        .sew_i   (sew_i),
        .lmul_i  (lmul_i),
        .vlmax_o (vlmax_w),
        .ill_o   (ill_w)
    );

    vlcfg_select #(.VLEN(VLEN), .XLEN(XLEN)) select_i (
        .avl_i      (avl_i),
        .vlmax_i    (vlmax_w),
        .ill_i      (ill_w),
        .rd_zero_i  (rd_zero_i),
        .rs1_zero_i (rs1_zero_i),
        .cur_vl_i   (st_q.vl),
        .nxt_vl_o   (nxt_vl_w)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rd_wen = 1'b0;
        if (cfg_valid_i) begin
            st_d.vl      = nxt_vl_w;
            st_d.ill     = ill_w;
            st_d.sew     = ill_w ? 3'd0 : sew_i;
            st_d.lmul    = ill_w ? 3'd0 : lmul_i;
            st_d.rd_wen  = !rd_zero_i;
            st_d.rd_data = XLEN'(nxt_vl_w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{vl: '0, sew: 3'd0, lmul: 3'd0, ill: 1'b1,
                      rd_wen: 1'b0, rd_data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign vl_o       = st_q.vl;
    assign sew_o      = st_q.sew;
    assign lmul_o     = st_q.lmul;
    assign ill_o      = st_q.ill;
    assign rd_wen_o   = st_q.rd_wen;
    assign rd_wdata_o = st_q.rd_data;
    assign vlenb_o    = XLEN'(VLEN / 8);

endmodule

// File: rtl/vlcfg_chk.sv
module vlcfg_chk #(
    parameter int VLEN = 128,
    parameter int XLEN = 32,
    localparam int VLW = $clog2(VLEN) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_valid_i,
    input logic            rd_zero_i,
    input logic            rs1_zero_i,
    input logic [VLW-1:0]  vl_o,
    input logic [2:0]      sew_o,
    input logic [2:0]      lmul_o,
    input logic            ill_o,
    input logic            rd_wen_o,
    input logic [XLEN-1:0] rd_wdata_o
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid_i |=> ($stable(vl_o) && $stable(ill_o) && $stable(sew_o) && $stable(lmul_o)));

    p_vl_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vl_o <= VLW'(VLEN));

    p_keep_vl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid_i && rd_zero_i && rs1_zero_i) |=> (ill_o || vl_o == $past(vl_o)));

    p_ill_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ill_o |-> (vl_o == '0 && sew_o == 3'd0 && lmul_o == 3'd0));

    p_rd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid_i && !rd_zero_i) |=> (rd_wen_o && rd_wdata_o == XLEN'(vl_o)));

    p_rd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid_i && !rd_zero_i) |=> !rd_wen_o);

endmodule

bind vlcfg_unit vlcfg_chk #(.VLEN(VLEN), .XLEN(XLEN)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_valid_i (cfg_valid_i),
    .rd_zero_i   (rd_zero_i),
    .rs1_zero_i  (rs1_zero_i),
    .vl_o        (vl_o),
    .sew_o       (sew_o),
    .lmul_o      (lmul_o),
    .ill_o       (ill_o),
    .rd_wen_o    (rd_wen_o),
    .rd_wdata_o  (rd_wdata_o)
);

// File: tb/vlcfg_unit_tb.sv
module vlcfg_unit_tb_top;
    localparam int VLEN = 128;
    localparam int XLEN = 32;
    localparam int VLW  = $clog2(VLEN) + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_valid_i = 1'b0;
    logic [XLEN-1:0] avl_i = '0;
    logic            rd_zero_i = 1'b0;
    logic            rs1_zero_i = 1'b0;
    logic [2:0]      sew_i = '0;
    logic [2:0]      lmul_i = '0;
    logic [VLW-1:0]  vl_o;
    logic [2:0]      sew_o, lmul_o;
    logic            ill_o, rd_wen_o;
    logic [XLEN-1:0] rd_wdata_o, vlenb_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    vlcfg_unit #(.VLEN(VLEN), .XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_valid_i(cfg_valid_i), .avl_i(avl_i),
        .rd_zero_i(rd_zero_i), .rs1_zero_i(rs1_zero_i), .sew_i(sew_i), .lmul_i(lmul_i),
        .vl_o(vl_o), .sew_o(sew_o), .lmul_o(lmul_o), .ill_o(ill_o),
        .rd_wen_o(rd_wen_o), .rd_wdata_o(rd_wdata_o), .vlenb_o(vlenb_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Independent VLMAX model; -1 marks an illegal request
    function automatic int model_vlmax(input int sew, input int lmul);
        int bits, num, den;
        if (sew > 3 || lmul == 4) return -1;
        bits = 8 << sew;
        num = (lmul <= 3) ? (1 << lmul) : 1;
        den = (lmul == 7) ? 2 : (lmul == 6) ? 4 : (lmul == 5) ? 8 : 1;
        if ((VLEN * num) / (bits * den) < 1) return -1;
        return (VLEN * num) / (bits * den);
    endfunction

    task automatic issue(input int avl, input bit rdz, input bit rs1z, input int sew, input int lmul);
        @(negedge clk);
        avl_i = XLEN'(avl); rd_zero_i = rdz; rs1_zero_i = rs1z;
        sew_i = 3'(sew); lmul_i = 3'(lmul); cfg_valid_i = 1'b1;
        @(negedge clk);
        cfg_valid_i = 1'b0;
    endtask

    task automatic expect_cfg(input string req, input int vl, input int sew, input int lmul, input bit ill);
        check({req, " vl"}, vl_o, vl);
        check({req, " sew"}, sew_o, sew);
        check({req, " lmul"}, lmul_o, lmul);
        check({req, " ill"}, ill_o, ill);
    endtask

    task automatic t_reset();
        expect_cfg("R1 reset", 0, 0, 0, 1);
        check("R1 reset rd_wen", rd_wen_o, 0);
        check("R9 vlenb", vlenb_o, VLEN / 8);
    endtask

    task automatic t_normal();
        int m;
        m = model_vlmax(0, 0); // 16
        issue(5, 0, 0, 0, 0);
        expect_cfg("R3 below", 5, 0, 0, 0);
        check("R8 rd_wen", rd_wen_o, 1);
        check("R8 rd_wdata", rd_wdata_o, 5);
        issue(m - 1, 0, 0, 0, 0);
        check("R3 max-1", vl_o, m - 1);
        issue(m, 0, 0, 0, 0);
        check("R3 exact", vl_o, m);
        issue(1000, 0, 0, 0, 0);
        check("R3 over", vl_o, m);
        issue(1000, 0, 0, 2, 3);
        expect_cfg("R3 sew32 x8", model_vlmax(2, 3), 2, 3, 0);
        @(negedge clk);
        check("R8 one-cycle pulse", rd_wen_o, 0);
    endtask

    task automatic t_fractional();
        issue(100, 0, 0, 0, 5);
        expect_cfg("R6 e8 1/8", model_vlmax(0, 5), 0, 5, 0);
        issue(100, 0, 0, 1, 7);
        expect_cfg("R6 e16 1/2", model_vlmax(1, 7), 1, 7, 0);
        issue(100, 0, 0, 0, 6);
        check("R6 e8 1/4", vl_o, model_vlmax(0, 6));
    endtask

    task automatic t_zero_forms();
        issue(3, 0, 1, 1, 1);
        expect_cfg("R4 max request", model_vlmax(1, 1), 1, 1, 0);
        check("R4 rd_wdata", rd_wdata_o, model_vlmax(1, 1));
        issue(2, 1, 1, 0, 2);
        expect_cfg("R5 keep vl", model_vlmax(1, 1), 0, 2, 0);
        check("R8 no write rd zero", rd_wen_o, 0);
        issue(4, 1, 0, 0, 0);
        check("R3 rd zero still sets vl", vl_o, 4);
        check("R8 rd zero no wen", rd_wen_o, 0);
    endtask

    task automatic t_illegal();
        issue(8, 0, 0, 3, 5);
        expect_cfg("R7 e64 1/8", 0, 0, 0, 1);
        issue(8, 0, 0, 0, 0);
        issue(8, 0, 0, 4, 0);
        expect_cfg("R7 rsvd sew", 0, 0, 0, 1);
        issue(8, 0, 0, 0, 0);
        issue(8, 0, 0, 0, 4);
        expect_cfg("R7 rsvd lmul", 0, 0, 0, 1);
        issue(8, 0, 0, 0, 0);
        issue(8, 1, 1, 3, 6);
        expect_cfg("R7 keep form illegal", 0, 0, 0, 1);
    endtask

    task automatic t_hold();
        issue(9, 0, 0, 1, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            avl_i = XLEN'(i); sew_i = 3'(i); lmul_i = 3'(i + 1); rs1_zero_i = i[0];
        end
        @(negedge clk);
        expect_cfg("R2 hold without strobe", 8, 1, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_fractional();
        t_zero_forms();
        t_illegal();
        t_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule